// File: doc/BRIEF.md
# Multi-stage redirect epoch controller

This block steers control-flow recovery for an in-order pipeline in which two stages may correct the fetch address: decode, after it consults its own direction predictor, and execute, once the real outcome of an instruction is known. Each of those two stages owns a one-bit epoch that it flips when it redirects. Fetch keeps its own guesses of both epochs, and decode keeps a guess of the execute epoch. Every fetched instruction is stamped with the guesses fetch holds at that moment. The stamps are later compared against the live epochs, which sorts each instruction into one of three outcomes: carried forward, discarded quietly at decode, or poisoned at execute.

The block contains the program counter and two one-entry stage registers, fetch-to-decode and decode-to-execute. Each of these accepts a new entry only when the previous one leaves. Redirect messages from decode and execute are registered, and fetch consumes them one cycle later. When both arrive in the same cycle, execute wins. A decode message is discarded if its execute stamp no longer matches fetch's guess. The prediction structures and the datapath sit outside: the next-address guess, decode's prediction and the resolved target are all plain inputs.

Top module: `redirect_epoch_ctrl`

## Requirements
- R1: On reset the fetch address equals the RESET_PC parameter, both stage registers are empty, no training message is valid, and all epochs and epoch guesses are 0.
- R2: When no redirect is applied, fetch_req_i is high and the decode slot is free or emptying, fetch fires and the next fetch address is pred_pc_i. If fetch does not fire and no redirect is applied, the fetch address holds.
- R3: An instruction at execute whose execute stamp differs from the execute epoch raises exe_poison_o. It causes neither a redirect nor a training message.
- R4: An unpoisoned instruction that leaves execute with exe_target_i not equal to its predicted next address flips the execute epoch. One cycle later, fetch loads exe_target_i and flips its guess of the execute epoch.
- R5: At decode, an instruction whose execute stamp matches decode's guess but whose decode stamp differs from the decode epoch raises dec_drop_o. It is removed without being forwarded and without waiting for execute.
- R6: At decode, an instruction whose execute stamp differs from decode's guess first loads that guess from its execute stamp and the decode epoch from its decode stamp. It is then treated as a correct-path instruction.
- R7: A correct-path instruction leaving decode with dec_pred_pc_i not equal to its predicted next address raises dec_redirect_o and flips the decode epoch. It is forwarded with dec_pred_pc_i as its new predicted next address. Its message carries the new decode epoch and the instruction's execute stamp.
- R8: When an execute message and a decode message reach fetch in the same cycle, the execute target is loaded and the decode message is discarded.
- R9: A decode message is applied only when its execute stamp equals fetch's guess of the execute epoch. When applied, fetch loads the message address and takes its decode-epoch value as the new guess.
- R10: Each unpoisoned instruction that leaves execute with exe_ctrl_i high produces train_valid_o high for exactly the next cycle. The message carries that instruction's pc, exe_target_i, exe_taken_i, and whether it mispredicted.
- R11: Fetch does not fire in a cycle in which a redirect is applied.
- R12: While the execute slot is full and exe_ready_i is low, the execute slot and the decode slot hold their contents and fetch does not fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_req_i | input | 1 | Instruction memory can take a fetch this cycle |
| pred_pc_i | input | AW | Predicted next address for fetch_pc_o |
| fetch_pc_o | output | AW | Current fetch address |
| fetch_fire_o | output | 1 | Fetch of fetch_pc_o happens this cycle |
| dec_valid_o | output | 1 | Decode slot holds an instruction |
| dec_pc_o | output | AW | Address of the instruction at decode |
| dec_ppc_o | output | AW | Its predicted next address |
| dec_pred_pc_i | input | AW | Decode-stage prediction for that instruction |
| dec_drop_o | output | 1 | Instruction at decode is wrong-path and is removed |
| dec_redirect_o | output | 1 | Decode redirects this cycle |
| exe_valid_o | output | 1 | Execute slot holds an instruction |
| exe_pc_o | output | AW | Address of the instruction at execute |
| exe_ppc_o | output | AW | Its predicted next address |
| exe_target_i | input | AW | Resolved next address |
| exe_ctrl_i | input | 1 | Instruction at execute is a control instruction |
| exe_taken_i | input | 1 | Resolved branch direction |
| exe_ready_i | input | 1 | Execute consumes its instruction this cycle |
| exe_poison_o | output | 1 | Instruction at execute is poisoned |
| train_valid_o | output | 1 | Training message valid |
| train_pc_o | output | AW | Training: instruction address |
| train_target_o | output | AW | Training: resolved target |
| train_taken_o | output | 1 | Training: direction |
| train_mispredict_o | output | 1 | Training: prediction was wrong |

## Verification
The bench sets AW to 12 and RESET_PC to 0x040, so every address fits in three hex digits and the traced program stays in a small window. With those values a short cycle table can walk several cases in sequence: a same-cycle clash between execute and decode redirects, a decode drop, an epoch adoption at decode that follows an execute redirect, an accepted decode redirect, and a stale decode message that must be rejected. Directed steps then stall execute, idle fetch and reset the block in the middle of a run.

// File: rtl/redirect_epoch_pkg.sv
package redirect_epoch_pkg;

  typedef enum logic [1:0] {
    NPC_HOLD,
    NPC_PRED,
    NPC_DEC,
    NPC_EXE
  } npc_sel_e;

  typedef enum logic [1:0] {
    DACT_PASS,
    DACT_ADOPT,
    DACT_DROP
  } dec_act_e;

  typedef struct packed {
    logic eep;
    logic dep;
  } epoch_tag_t;

endpackage

// File: rtl/rep_fetch.sv
module rep_fetch
  import redirect_epoch_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fetch_req_i,
  input  logic [AW-1:0] pred_pc_i,
  input  logic          f2d_space_i,
  input  logic          exe_msg_v_i,
  input  logic [AW-1:0] exe_msg_pc_i,
  input  logic          dec_msg_v_i,
  input  logic [AW-1:0] dec_msg_pc_i,
  input  epoch_tag_t    dec_msg_tag_i,
  output logic [AW-1:0] pc_o,
  output logic          fire_o,
  output epoch_tag_t    tag_o,
  output logic          redir_take_o
);

  logic [AW-1:0] pc_q, pc_d;
  logic          fe_eep_q, fd_dep_q;
  logic          dec_ok;
  npc_sel_e      sel;

  // stale decode messages are recognised by their execute stamp
  assign dec_ok = dec_msg_v_i && (dec_msg_tag_i.eep == fe_eep_q);

  always_comb begin
    if (exe_msg_v_i)                     sel = NPC_EXE;
    else if (dec_ok)                     sel = NPC_DEC;
    else if (fetch_req_i && f2d_space_i) sel = NPC_PRED;
    else                                 sel = NPC_HOLD;
  end

  always_comb begin
    unique case (sel)
      NPC_EXE:  pc_d = exe_msg_pc_i;
      NPC_DEC:  pc_d = dec_msg_pc_i;
      NPC_PRED: pc_d = pred_pc_i;
      default:  pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= RESET_PC;
      fe_eep_q <= 1'b0;
      fd_dep_q <= 1'b0;
    end else begin
      pc_q <= pc_d;
      if (sel == NPC_EXE) fe_eep_q <= ~fe_eep_q;
      if (sel == NPC_DEC) fd_dep_q <= dec_msg_tag_i.dep;
    end
  end

  assign pc_o         = pc_q;
  assign fire_o       = (sel == NPC_PRED);
  assign redir_take_o = (sel == NPC_EXE) || (sel == NPC_DEC);
  assign tag_o        = '{eep: fe_eep_q, dep: fd_dep_q};

endmodule

// File: rtl/rep_decode.sv
module rep_decode
  import redirect_epoch_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] push_pc_i,
  input  logic [AW-1:0] push_ppc_i,
  input  epoch_tag_t    push_tag_i,
  input  logic [AW-1:0] pred_pc_i,
  input  logic          d2e_space_i,
  output logic          space_o,
  output logic          valid_o,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] ppc_o,
  output logic          drop_o,
  output logic          redirect_o,
  output logic          fwd_o,
  output logic [AW-1:0] fwd_ppc_o,
  output logic          fwd_eep_o,
  output logic          msg_v_o,
  output logic [AW-1:0] msg_pc_o,
  output epoch_tag_t    msg_tag_o
);

  logic          valid_q;
  logic [AW-1:0] pc_q, ppc_q;
  epoch_tag_t    tag_q;
  logic          de_eep_q, d_dep_q;
  dec_act_e      act;
  logic          eff_dep, mis, leave;

  always_comb begin
    if (tag_q.eep != de_eep_q)     act = DACT_ADOPT;
    else if (tag_q.dep != d_dep_q) act = DACT_DROP;
    else                           act = DACT_PASS;
  end

  assign eff_dep = (act == DACT_ADOPT) ? tag_q.dep : d_dep_q;
  assign mis     = (act != DACT_DROP) && (pred_pc_i != ppc_q);
  // a drop needs no room downstream
  assign leave   = valid_q && ((act == DACT_DROP) || d2e_space_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      pc_q     <= '0;
      ppc_q    <= '0;
      tag_q    <= '0;
      de_eep_q <= 1'b0;
      d_dep_q  <= 1'b0;
    end else begin
      if (push_i) begin
        valid_q <= 1'b1;
        pc_q    <= push_pc_i;
        ppc_q   <= push_ppc_i;
        tag_q   <= push_tag_i;
      end else if (leave) begin
        valid_q <= 1'b0;
      end
      if (leave && (act != DACT_DROP)) begin
        de_eep_q <= tag_q.eep;
        d_dep_q  <= mis ? ~eff_dep : eff_dep;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_v_o   <= 1'b0;
      msg_pc_o  <= '0;
      msg_tag_o <= '0;
    end else begin
      msg_v_o <= leave && mis;
      if (leave && mis) begin
        msg_pc_o  <= pred_pc_i;
        msg_tag_o <= '{eep: tag_q.eep, dep: ~eff_dep};
      end
    end
  end

  assign space_o    = !valid_q || leave;
  assign valid_o    = valid_q;
  assign pc_o       = pc_q;
  assign ppc_o      = ppc_q;
  assign drop_o     = valid_q && (act == DACT_DROP);
  assign redirect_o = leave && mis;
  assign fwd_o      = leave && (act != DACT_DROP);
  assign fwd_ppc_o  = pred_pc_i;
  assign fwd_eep_o  = tag_q.eep;

endmodule

// File: rtl/rep_execute.sv
module rep_execute #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] push_pc_i,
  input  logic [AW-1:0] push_ppc_i,
  input  logic          push_eep_i,
  input  logic          ready_i,
  input  logic [AW-1:0] target_i,
  input  logic          ctrl_i,
  input  logic          taken_i,
  output logic          space_o,
  output logic          valid_o,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] ppc_o,
  output logic          poison_o,
  output logic          msg_v_o,
  output logic [AW-1:0] msg_pc_o,
  output logic          train_v_o,
  output logic [AW-1:0] train_pc_o,
  output logic [AW-1:0] train_tgt_o,
  output logic          train_taken_o,
  output logic          train_mis_o
);

  logic          valid_q, eep_q, e_eep_q;
  logic [AW-1:0] pc_q, ppc_q;
  logic          go, poison, mis, live;

  assign poison = eep_q != e_eep_q;
  assign go     = valid_q && ready_i;
  assign mis    = target_i != ppc_q;
  assign live   = go && !poison;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      pc_q    <= '0;
      ppc_q   <= '0;
      eep_q   <= 1'b0;
      e_eep_q <= 1'b0;
    end else begin
      if (push_i) begin
        valid_q <= 1'b1;
        pc_q    <= push_pc_i;
        ppc_q   <= push_ppc_i;
        eep_q   <= push_eep_i;
      end else if (go) begin
        valid_q <= 1'b0;
      end
      if (live && mis) e_eep_q <= ~e_eep_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_v_o       <= 1'b0;
      msg_pc_o      <= '0;
      train_v_o     <= 1'b0;
      train_pc_o    <= '0;
      train_tgt_o   <= '0;
      train_taken_o <= 1'b0;
      train_mis_o   <= 1'b0;
    end else begin
      msg_v_o   <= live && mis;
      train_v_o <= live && ctrl_i;
      if (live && mis) msg_pc_o <= target_i;
      if (live && ctrl_i) begin
        train_pc_o    <= pc_q;
        train_tgt_o   <= target_i;
        train_taken_o <= taken_i;
        train_mis_o   <= mis;
      end
    end
  end

  assign space_o  = !valid_q || ready_i;
  assign valid_o  = valid_q;
  assign pc_o     = pc_q;
  assign ppc_o    = ppc_q;
  assign poison_o = valid_q && poison;

endmodule

// File: rtl/redirect_epoch_ctrl.sv
module redirect_epoch_ctrl
  import redirect_epoch_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] RESET_PC = 16'h0100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fetch_req_i,
  input  logic [AW-1:0] pred_pc_i,
  output logic [AW-1:0] fetch_pc_o,
  output logic          fetch_fire_o,
  output logic          dec_valid_o,
  output logic [AW-1:0] dec_pc_o,
  output logic [AW-1:0] dec_ppc_o,
  input  logic [AW-1:0] dec_pred_pc_i,
  output logic          dec_drop_o,
  output logic          dec_redirect_o,
  output logic          exe_valid_o,
  output logic [AW-1:0] exe_pc_o,
  output logic [AW-1:0] exe_ppc_o,
  input  logic [AW-1:0] exe_target_i,
  input  logic          exe_ctrl_i,
  input  logic          exe_taken_i,
  input  logic          exe_ready_i,
  output logic          exe_poison_o,
  output logic          train_valid_o,
  output logic [AW-1:0] train_pc_o,
  output logic [AW-1:0] train_target_o,
  output logic          train_taken_o,
  output logic          train_mispredict_o
);

  epoch_tag_t    fetch_tag, dec_msg_tag;
  logic          f2d_space, d2e_space, redir_take;
  logic          dec_fwd, dec_fwd_eep, dec_msg_v, exe_msg_v;
  logic [AW-1:0] dec_fwd_ppc, dec_msg_pc, exe_msg_pc;

  rep_fetch #(.AW(AW), .RESET_PC(RESET_PC)) u_fetch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fetch_req_i  (fetch_req_i),
    .pred_pc_i    (pred_pc_i),
    .f2d_space_i  (f2d_space),
    .exe_msg_v_i  (exe_msg_v),
    .exe_msg_pc_i (exe_msg_pc),
    .dec_msg_v_i  (dec_msg_v),
    .dec_msg_pc_i (dec_msg_pc),
    .dec_msg_tag_i(dec_msg_tag),
    .pc_o         (fetch_pc_o),
    .fire_o       (fetch_fire_o),
    .tag_o        (fetch_tag),
    .redir_take_o (redir_take)
  );

  rep_decode #(.AW(AW)) u_decode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (fetch_fire_o),
    .push_pc_i  (fetch_pc_o),
    .push_ppc_i (pred_pc_i),
    .push_tag_i (fetch_tag),
    .pred_pc_i  (dec_pred_pc_i),
    .d2e_space_i(d2e_space),
    .space_o    (f2d_space),
    .valid_o    (dec_valid_o),
    .pc_o       (dec_pc_o),
    .ppc_o      (dec_ppc_o),
    .drop_o     (dec_drop_o),
    .redirect_o (dec_redirect_o),
    .fwd_o      (dec_fwd),
    .fwd_ppc_o  (dec_fwd_ppc),
    .fwd_eep_o  (dec_fwd_eep),
    .msg_v_o    (dec_msg_v),
    .msg_pc_o   (dec_msg_pc),
    .msg_tag_o  (dec_msg_tag)
  );

  rep_execute #(.AW(AW)) u_execute (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (dec_fwd),
    .push_pc_i    (dec_pc_o),
    .push_ppc_i   (dec_fwd_ppc),
    .push_eep_i   (dec_fwd_eep),
    .ready_i      (exe_ready_i),
    .target_i     (exe_target_i),
    .ctrl_i       (exe_ctrl_i),
    .taken_i      (exe_taken_i),
    .space_o      (d2e_space),
    .valid_o      (exe_valid_o),
    .pc_o         (exe_pc_o),
    .ppc_o        (exe_ppc_o),
    .poison_o     (exe_poison_o),
    .msg_v_o      (exe_msg_v),
    .msg_pc_o     (exe_msg_pc),
    .train_v_o    (train_valid_o),
    .train_pc_o   (train_pc_o),
    .train_tgt_o  (train_target_o),
    .train_taken_o(train_taken_o),
    .train_mis_o  (train_mispredict_o)
  );

endmodule

// File: rtl/redirect_epoch_ctrl_chk.sv
module redirect_epoch_ctrl_chk #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fetch_fire_o,
  input logic [AW-1:0] fetch_pc_o,
  input logic [AW-1:0] pred_pc_i,
  input logic          exe_valid_o,
  input logic          exe_ready_i,
  input logic          exe_poison_o,
  input logic          exe_ctrl_i,
  input logic [AW-1:0] exe_pc_o,
  input logic          train_valid_o,
  input logic          exe_msg_v,
  input logic [AW-1:0] exe_msg_pc,
  input logic          redir_take
);

  a_r2_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_fire_o |=> fetch_pc_o == $past(pred_pc_i));

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fetch_fire_o && !redir_take) |=> $stable(fetch_pc_o));

  a_r8_exe_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exe_msg_v |=> fetch_pc_o == $past(exe_msg_pc));

  a_r3_poison_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exe_poison_o && exe_ready_i) |=> (!train_valid_o && !exe_msg_v));

  a_r10_train_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    train_valid_o |-> $past(exe_valid_o && exe_ready_i && !exe_poison_o && exe_ctrl_i));

  a_r12_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exe_valid_o && !exe_ready_i) |=> (exe_valid_o && $stable(exe_pc_o)));

endmodule

bind redirect_epoch_ctrl redirect_epoch_ctrl_chk #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fetch_fire_o (fetch_fire_o),
  .fetch_pc_o   (fetch_pc_o),
  .pred_pc_i    (pred_pc_i),
  .exe_valid_o  (exe_valid_o),
  .exe_ready_i  (exe_ready_i),
  .exe_poison_o (exe_poison_o),
  .exe_ctrl_i   (exe_ctrl_i),
  .exe_pc_o     (exe_pc_o),
  .train_valid_o(train_valid_o),
  .exe_msg_v    (exe_msg_v),
  .exe_msg_pc   (exe_msg_pc),
  .redir_take   (redir_take)
);

// File: tb/redirect_epoch_ctrl_test.sv
`timescale 1ns/1ps
module redirect_epoch_ctrl_test;

  localparam int AW = 12;

  typedef struct packed {
    logic          fr;
    logic          dsel;
    logic [AW-1:0] dalt;
    logic          esel;
    logic [AW-1:0] ealt;
    logic          ectl;
    logic          etkn;
    logic [AW-1:0] pc;
    logic          dv;
    logic          ev;
    logic          drop;
    logic          dredir;
    logic          poi;
    logic          tr;
    logic [AW-1:0] tpc;
    logic [AW-1:0] ttgt;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,12'h000,1'b0,12'h000,1'b0,1'b0, 12'h040,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,12'h000,12'h000},
    '{1'b1,1'b0,12'h000,1'b0,12'h000,1'b0,1'b0, 12'h044,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,12'h000,12'h000},
    '{1'b1,1'b1,12'h060,1'b1,12'h080,1'b1,1'b1, 12'h048,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,12'h000,12'h000},
    '{1'b1,1'b0,12'h000,1'b0,12'h000,1'b0,1'b0, 12'h04C,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,12'h040,12'h080},
    '{1'b1,1'b0,12'h000,1'b0,12'h000,1'b0,1'b0, 12'h080,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,12'h000,12'h000},
    '{1'b1,1'b0,12'h000,1'b0,12'h000,1'b0,1'b0, 12'h084,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,12'h000,12'h000},
    '{1'b1,1'b1,12'h0A0,1'b0,12'h000,1'b0,1'b0, 12'h088,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,12'h000,12'h000},
    '{1'b1,1'b0,12'h000,1'b0,12'h000,1'b0,1'b0, 12'h08C,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,12'h000,12'h000},
    '{1'b1,1'b0,12'h000,1'b0,12'h000,1'b0,1'b0, 12'h0A0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,12'h000,12'h000},
    '{1'b1,1'b0,12'h000,1'b0,12'h000,1'b0,1'b0, 12'h0A4,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,12'h000,12'h000},
    '{1'b1,1'b0,12'h000,1'b1,12'h0C0,1'b1,1'b1, 12'h0A8,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,12'h000,12'h000},
    '{1'b1,1'b1,12'h0E0,1'b0,12'h000,1'b0,1'b0, 12'h0AC,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,12'h0A0,12'h0C0},
    '{1'b1,1'b0,12'h000,1'b0,12'h000,1'b0,1'b0, 12'h0C0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,12'h000,12'h000},
    '{1'b1,1'b0,12'h000,1'b0,12'h000,1'b0,1'b0, 12'h0C4,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,12'h000,12'h000},
    '{1'b1,1'b0,12'h000,1'b0,12'h000,1'b0,1'b0, 12'h0C8,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,12'h000,12'h000}
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          fetch_req, dsel, esel, ectl, etkn, exe_ready;
  logic [AW-1:0] dalt, ealt;
  logic [AW-1:0] pred_pc, fetch_pc, dec_pc, dec_ppc, dec_pred, exe_pc, exe_ppc, exe_target;
  logic [AW-1:0] train_pc, train_target;
  logic          fetch_fire, dec_valid, dec_drop, dec_redirect, exe_valid, exe_poison;
  logic          train_valid, train_taken, train_mis;
  int            checks = 0;
  int            errors = 0;

  always #2.5 clk = ~clk;

  assign pred_pc    = fetch_pc + 12'd4;
  assign dec_pred   = dsel ? dalt : dec_ppc;
  assign exe_target = esel ? ealt : exe_ppc;

  redirect_epoch_ctrl #(.AW(AW), .RESET_PC(12'h040)) uut (
    .clk_i             (clk),
    .rst_ni            (rst_ni),
    .fetch_req_i       (fetch_req),
    .pred_pc_i         (pred_pc),
    .fetch_pc_o        (fetch_pc),
    .fetch_fire_o      (fetch_fire),
    .dec_valid_o       (dec_valid),
    .dec_pc_o          (dec_pc),
    .dec_ppc_o         (dec_ppc),
    .dec_pred_pc_i     (dec_pred),
    .dec_drop_o        (dec_drop),
    .dec_redirect_o    (dec_redirect),
    .exe_valid_o       (exe_valid),
    .exe_pc_o          (exe_pc),
    .exe_ppc_o         (exe_ppc),
    .exe_target_i      (exe_target),
    .exe_ctrl_i        (ectl),
    .exe_taken_i       (etkn),
    .exe_ready_i       (exe_ready),
    .exe_poison_o      (exe_poison),
    .train_valid_o     (train_valid),
    .train_pc_o        (train_pc),
    .train_target_o    (train_target),
    .train_taken_o     (train_taken),
    .train_mispredict_o(train_mis)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic drive_idle(input logic fr, input logic rdy);
    fetch_req = fr; exe_ready = rdy;
    dsel = 1'b0; dalt = '0; esel = 1'b0; ealt = '0; ectl = 1'b0; etkn = 1'b0;
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    drive_idle(1'b0, 1'b1);
    repeat (2) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 fetch_pc", fetch_pc, 12'h040);
    chk("R1 dec_valid", dec_valid, 0);
    chk("R1 exe_valid", exe_valid, 0);
    chk("R1 train_valid", train_valid, 0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      fetch_req = VECS[i].fr;  exe_ready = 1'b1;
      dsel = VECS[i].dsel;     dalt = VECS[i].dalt;
      esel = VECS[i].esel;     ealt = VECS[i].ealt;
      ectl = VECS[i].ectl;     etkn = VECS[i].etkn;
      @(negedge clk);
      $display("cycle %0d", i);
      chk("R2 R4 R8 R9 R11 fetch_pc", fetch_pc, VECS[i].pc);
      chk("R5 R11 dec_valid", dec_valid, VECS[i].dv);
      chk("R7 exe_valid", exe_valid, VECS[i].ev);
      chk("R5 R6 dec_drop", dec_drop, VECS[i].drop);
      chk("R7 dec_redirect", dec_redirect, VECS[i].dredir);
      chk("R3 exe_poison", exe_poison, VECS[i].poi);
      chk("R10 train_valid", train_valid, VECS[i].tr);
      if (VECS[i].tr) begin
        chk("R10 train_pc", train_pc, VECS[i].tpc);
        chk("R10 train_target", train_target, VECS[i].ttgt);
        chk("R10 train_taken", train_taken, 1);
        chk("R10 train_mispredict", train_mis, 1);
      end
      @(posedge clk);
      #1;
    end

    // R12 stall: execute not ready holds both slots, fetch stops
    drive_idle(1'b1, 1'b0);
    @(negedge clk);
    chk("R12 fetch_fire", fetch_fire, 0);
    @(posedge clk);
    #1;
    drive_idle(1'b0, 1'b1);
    @(negedge clk);
    chk("R12 fetch_pc", fetch_pc, 12'h0CC);
    chk("R12 dec_pc", dec_pc, 12'h0C8);
    chk("R12 exe_pc", exe_pc, 12'h0C4);
    // R2 hold: no request, no redirect
    chk("R2 fetch_fire idle", fetch_fire, 0);
    @(posedge clk);
    #1;
    @(negedge clk);
    chk("R2 fetch_pc held", fetch_pc, 12'h0CC);
    chk("R2 dec_valid drained", dec_valid, 0);
    chk("R6 exe_pc forwarded", exe_pc, 12'h0C8);
    chk("R6 exe_poison", exe_poison, 0);

    // R1 reset in mid-run
    rst_ni = 1'b0;
    #1;
    chk("R1 fetch_pc mid", fetch_pc, 12'h040);
    chk("R1 exe_valid mid", exe_valid, 0);
    @(posedge clk);
    #1;
    rst_ni = 1'b1;
    drive_idle(1'b1, 1'b1);
    @(negedge clk);
    chk("R1 fetch_fire after reset", fetch_fire, 1);
    @(posedge clk);
    #1;
    @(negedge clk);
    chk("R1 R2 fetch_pc after reset", fetch_pc, 12'h044);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule